// File: doc/BRIEF.md
# Jitter Attenuator Elastic Store with Near-Limit Clock Acceleration

This block is a one-bit-wide elastic store for a jitter attenuation path. A recovered line timing writes bits into the store. A smoothed, digitally generated read timing takes them out. Both timings reach the block as single-cycle strobes (`wr_stb`, `rd_stb`) on one fast system clock. The programmed store depth is 8, 16, 32, 64 or 128 bits. In steady state the occupancy sits at half of that depth.

The occupancy is measured in eighths of a bit. Each whole bit held counts as eight eighths. The read-clock generator adds `sub_phase`, which is the part of a bit, in eighths, that it has not yet consumed. When the measure comes within one bit of either limit and acceleration is enabled, a state machine asks the read-clock generator for signed phase steps. The step count grows with proximity to the limit, up to 8 steps of 5 ns each (40 ns). Near the full limit the request is to speed up; near the empty limit it is to slow down.

Software drives a level-sensitive recenter. Raising it and then lowering it empties the write side and places the occupancy at half the programmed depth. Entry into acceleration raises a one-cycle interrupt pulse and a sticky bit. A real slip raises a separate sticky store-error bit. Software must hold `accel_en` low while the read clock free-runs.

State machine:
- States: `ST_CENTER` (recenter held), `ST_TRACK` (normal), `ST_ACC_UP` (speeding up near full) and `ST_ACC_DN` (slowing down near empty).
- Transitions:
  - Any state goes to `ST_CENTER` while recenter is high.
  - `ST_CENTER` goes to `ST_TRACK` on release.
  - `ST_TRACK`, `ST_ACC_UP` and `ST_ACC_DN` each move to `ST_ACC_UP` when near-full and enabled, to `ST_ACC_DN` when near-empty and enabled, and otherwise to `ST_TRACK`.

Top module: `jitter_es_top`

## Requirements
- R1: One cycle after recenter is sampled high, `fill` equals half the depth selected by `size_sel`: 000→8, 001→16, 010→32, 011→64, and any code with bit 2 set→128.
- R2: Recenter is level-sensitive. While it is held, write and read strobes are ignored, `fill` stays at half depth, and `clk_err_sticky` and `store_err` are cleared. After release, strobes take effect again.
- R3: Bits leave the store in the order they were written, including when a write and a read share a cycle.
- R4: A write strobe while `fill` equals the depth, with no accepted read in that cycle, is dropped. `fill` stays at the depth and `store_err` is set. `store_err` stays set until a recenter.
- R5: A read strobe while `fill` is 0 is dropped. `fill` stays 0 and `store_err` is set.
- R6: Let E = `fill`*8 + `sub_phase`. When `accel_en` is high and E > (depth−1)*8, the outputs within two cycles are `step_req`=1, `step_up`=1 and `step_cnt`=min(E−(depth−1)*8, 8).
- R7: When `accel_en` is high and E < 8, the outputs within two cycles are `step_req`=1, `step_up`=0 and `step_cnt`=8−E.
- R8: Outside both windows, or when `accel_en` was low in the previous cycle, `step_req`=0 and `step_cnt`=0.
- R9: `clk_err_irq` pulses for exactly one cycle on each move from `ST_TRACK` into an acceleration state. `clk_err_sticky` is set with that pulse and holds until a recenter.
- R10: After reset, `fill`=0 and `step_req`, `clk_err_sticky` and `store_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Write strobe from the recovered timing |
| wr_bit | input | 1 | Bit to store |
| rd_stb | input | 1 | Read strobe from the smoothed timing |
| rd_bit | output | 1 | Last bit read out |
| size_sel | input | 3 | Depth select code |
| recenter | input | 1 | Level-sensitive recenter control |
| accel_en | input | 1 | Enables near-limit acceleration |
| sub_phase | input | SUB_W | Unconsumed fraction of the current bit, in eighths |
| fill | output | CNT_W | Whole bits held in the store |
| step_req | output | 1 | Phase-step request active |
| step_up | output | 1 | 1: speed up the read clock, 0: slow it down |
| step_cnt | output | SUB_W+1 | Number of 5 ns steps, 0 to 8 |
| clk_err_irq | output | 1 | One-cycle pulse on entry into acceleration |
| clk_err_sticky | output | 1 | Sticky acceleration flag |
| store_err | output | 1 | Sticky slip flag |

## Verification
The assertions check on every cycle that:
- a request always carries a step count from 1 to 8, and no request carries a count of zero;
- a disabled controller never requests;
- the interrupt never lasts two cycles;
- both sticky flags hold until a recenter;
- the occupancy is at half depth after any recenter cycle.

Only the bench scenarios show the rest:
- the exact step value for each whole fill level and sub-bit phase;
- FIFO ordering under offset write and read rates;
- that forced slips leave the fill pinned at its limit.

// File: rtl/ja_pkg.sv
package ja_pkg;

    typedef enum logic [1:0] {
        ST_CENTER = 2'd0,
        ST_TRACK  = 2'd1,
        ST_ACC_UP = 2'd2,
        ST_ACC_DN = 2'd3
    } ja_state_e;

    // Depth in bits for a size code; bit 2 set selects the largest store.
    function automatic int unsigned depth_of(input logic [2:0] code);
        if (code[2]) return 128;
        return 8 << code[1:0];
    endfunction

endpackage

// File: rtl/ja_store.sv
module ja_store #(
    parameter int MAX_DEPTH = 128,
    parameter int PTR_W     = $clog2(MAX_DEPTH),
    parameter int CNT_W     = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             wr_bit,
    input  logic             rd_stb,
    input  logic             recenter,
    input  logic [CNT_W-1:0] depth,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill,
    output logic             ovf_ev,
    output logic             unf_ev
);
    logic [MAX_DEPTH-1:0] mem;
    logic [PTR_W-1:0]     wr_ptr, rd_ptr, mask, half_ptr;
    logic [CNT_W-1:0]     count;
    logic                 wr_go, rd_go;

    assign mask     = PTR_W'(depth - 1'b1);
    assign half_ptr = PTR_W'(depth >> 1);
    assign rd_go    = rd_stb && !recenter && (count != '0);
    assign wr_go    = wr_stb && !recenter && ((count != depth) || rd_go);
    assign fill     = count;

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr] <= wr_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rd_bit <= 1'b0;
            ovf_ev <= 1'b0;
            unf_ev <= 1'b0;
        end else if (recenter) begin
            wr_ptr <= '0;
            rd_ptr <= half_ptr;
            count  <= depth >> 1;
            ovf_ev <= 1'b0;
            unf_ev <= 1'b0;
        end else begin
            if (wr_go) wr_ptr <= (wr_ptr + 1'b1) & mask;
            if (rd_go) begin
                rd_ptr <= (rd_ptr + 1'b1) & mask;
                rd_bit <= mem[rd_ptr];
            end
            count  <= count + CNT_W'(wr_go) - CNT_W'(rd_go);
            ovf_ev <= wr_stb && !wr_go;
            unf_ev <= rd_stb && !rd_go;
        end
    end
endmodule

// File: rtl/ja_proximity.sv
module ja_proximity #(
    parameter int CNT_W = 8,
    parameter int SUB_W = 3
) (
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] depth,
    input  logic [SUB_W-1:0] sub_phase,
    output logic             near_full,
    output logic             near_empty,
    output logic [SUB_W:0]   steps
);
    localparam int EFF_W    = CNT_W + SUB_W;
    localparam int STEP_MAX = 1 << SUB_W;

    logic [EFF_W-1:0] eff, hi_lim, over;

    // Occupancy in sub-bit units: whole bits scaled plus the unconsumed fraction.
    assign eff        = {fill, sub_phase};
    assign hi_lim     = {depth - 1'b1, {SUB_W{1'b0}}};
    assign over       = eff - hi_lim;
    assign near_full  = eff > hi_lim;
    assign near_empty = eff < EFF_W'(STEP_MAX);

    always_comb begin
        steps = '0;
        if (near_full) begin
            steps = (over > EFF_W'(STEP_MAX)) ? (SUB_W+1)'(STEP_MAX) : over[SUB_W:0];
        end else if (near_empty) begin
            steps = (SUB_W+1)'(STEP_MAX) - {1'b0, sub_phase};
        end
    end
endmodule

// File: rtl/ja_accel_fsm.sv
module ja_accel_fsm
    import ja_pkg::*;
#(
    parameter int SUB_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           recenter,
    input  logic           accel_en,
    input  logic           near_full,
    input  logic           near_empty,
    input  logic [SUB_W:0] steps,
    input  logic           ovf_ev,
    input  logic           unf_ev,
    output logic           step_req,
    output logic           step_up,
    output logic [SUB_W:0] step_cnt,
    output logic           clk_err_irq,
    output logic           clk_err_sticky,
    output logic           store_err
);
    ja_state_e state_q, state_d;
    ja_state_e pick;

    always_comb begin
        if (accel_en && near_full)       pick = ST_ACC_UP;
        else if (accel_en && near_empty) pick = ST_ACC_DN;
        else                             pick = ST_TRACK;
    end

    always_comb begin
        unique case (state_q)
            ST_CENTER: state_d = recenter ? ST_CENTER : ST_TRACK;
            ST_TRACK:  state_d = recenter ? ST_CENTER : pick;
            ST_ACC_UP: state_d = recenter ? ST_CENTER : pick;
            ST_ACC_DN: state_d = recenter ? ST_CENTER : pick;
            default:   state_d = ST_TRACK;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_cnt       <= '0;
            clk_err_irq    <= 1'b0;
            clk_err_sticky <= 1'b0;
            store_err      <= 1'b0;
        end else begin
            step_cnt    <= (state_d == ST_ACC_UP || state_d == ST_ACC_DN) ? steps : '0;
            clk_err_irq <= (state_q == ST_TRACK) &&
                           (state_d == ST_ACC_UP || state_d == ST_ACC_DN);
            if (state_d == ST_CENTER) begin
                clk_err_sticky <= 1'b0;
                store_err      <= 1'b0;
            end else begin
                if ((state_q == ST_TRACK) && (state_d != ST_TRACK)) clk_err_sticky <= 1'b1;
                if (ovf_ev || unf_ev) store_err <= 1'b1;
            end
        end
    end

    assign step_req = (state_q == ST_ACC_UP) || (state_q == ST_ACC_DN);
    assign step_up  = (state_q == ST_ACC_UP);
endmodule

// File: rtl/jitter_es_top.sv
module jitter_es_top #(
    parameter int MAX_DEPTH = 128,
    parameter int SUB_W     = 3,
    localparam int PTR_W    = $clog2(MAX_DEPTH),
    localparam int CNT_W    = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             wr_bit,
    input  logic             rd_stb,
    output logic             rd_bit,
    input  logic [2:0]       size_sel,
    input  logic             recenter,
    input  logic             accel_en,
    input  logic [SUB_W-1:0] sub_phase,
    output logic [CNT_W-1:0] fill,
    output logic             step_req,
    output logic             step_up,
    output logic [SUB_W:0]   step_cnt,
    output logic             clk_err_irq,
    output logic             clk_err_sticky,
    output logic             store_err
);
    logic [CNT_W-1:0] depth;
    logic             near_full, near_empty, ovf_ev, unf_ev;
    logic [SUB_W:0]   steps;

    always_comb begin
        if (ja_pkg::depth_of(size_sel) > MAX_DEPTH) depth = CNT_W'(MAX_DEPTH);
        else                                        depth = CNT_W'(ja_pkg::depth_of(size_sel));
    end

    ja_store #(.MAX_DEPTH(MAX_DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bit(wr_bit),
        .rd_stb(rd_stb), .recenter(recenter), .depth(depth),
        .rd_bit(rd_bit), .fill(fill), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
    );

    ja_proximity #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_prox (
        .fill(fill), .depth(depth), .sub_phase(sub_phase),
        .near_full(near_full), .near_empty(near_empty), .steps(steps)
    );

    ja_accel_fsm #(.SUB_W(SUB_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .recenter(recenter), .accel_en(accel_en),
        .near_full(near_full), .near_empty(near_empty), .steps(steps),
        .ovf_ev(ovf_ev), .unf_ev(unf_ev),
        .step_req(step_req), .step_up(step_up), .step_cnt(step_cnt),
        .clk_err_irq(clk_err_irq), .clk_err_sticky(clk_err_sticky),
        .store_err(store_err)
    );
endmodule

// File: rtl/ja_es_checker.sv
module ja_es_checker #(
    parameter int MAX_DEPTH = 128,
    parameter int SUB_W     = 3,
    localparam int CNT_W    = $clog2(MAX_DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             recenter,
    input logic             accel_en,
    input logic [2:0]       size_sel,
    input logic [CNT_W-1:0] fill,
    input logic             step_req,
    input logic [SUB_W:0]   step_cnt,
    input logic             clk_err_irq,
    input logic             clk_err_sticky,
    input logic             store_err
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r6_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (step_cnt != 0) && (step_cnt <= (SUB_W+1)'(1 << SUB_W)));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !step_req |-> (step_cnt == 0));

    a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!accel_en) |-> !step_req);

    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        clk_err_irq |=> !clk_err_irq);

    a_r9_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        clk_err_irq |-> clk_err_sticky);

    a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clk_err_sticky && !recenter |=> clk_err_sticky);

    a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        store_err && !recenter |=> store_err);

    a_r2_half: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(recenter) |->
            (int'(fill) == int'(ja_pkg::depth_of($past(size_sel)) > MAX_DEPTH ?
                MAX_DEPTH : ja_pkg::depth_of($past(size_sel))) / 2));
endmodule

bind jitter_es_top ja_es_checker #(.MAX_DEPTH(MAX_DEPTH), .SUB_W(SUB_W)) u_chk (.*);

// File: tb/tb_jitter_es_top.sv
`timescale 1ns/1ps
module tb_jitter_es_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0, wr_bit = 1'b0, rd_stb = 1'b0;
    logic       rd_bit;
    logic [2:0] size_sel = 3'd0;
    logic       recenter = 1'b0, accel_en = 1'b0;
    logic [2:0] sub_phase = 3'd0;
    logic [7:0] fill;
    logic       step_req, step_up, clk_err_irq, clk_err_sticky, store_err;
    logic [3:0] step_cnt;

    int compared = 0;
    int mismatched = 0;
    int irq_seen = 0;
    int cur = 0;
    bit done = 1'b0;
    logic got;
    logic [15:0] pat = 16'hA5C3;

    always #2.5 clk = ~clk;

    jitter_es_top dut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_bit(wr_bit),
        .rd_stb(rd_stb), .rd_bit(rd_bit), .size_sel(size_sel),
        .recenter(recenter), .accel_en(accel_en), .sub_phase(sub_phase),
        .fill(fill), .step_req(step_req), .step_up(step_up),
        .step_cnt(step_cnt), .clk_err_irq(clk_err_irq),
        .clk_err_sticky(clk_err_sticky), .store_err(store_err)
    );

    always @(negedge clk) if (clk_err_irq) irq_seen++;

    task automatic check(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rw(input logic w, input logic b, input logic r, output logic q);
        @(negedge clk);
        wr_stb = w; wr_bit = b; rd_stb = r;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        q = rd_bit;
    endtask

    function automatic int dep_of(input int code);
        return (code >= 4) ? 128 : (8 << code);
    endfunction

    task automatic do_recenter(input int code);
        @(negedge clk);
        size_sel = 3'(code); recenter = 1'b1;
        settle(2);
        recenter = 1'b0;
        settle(2);
        cur = dep_of(code) / 2;
    endtask

    task automatic move_to(input int lvl);
        logic q;
        while (cur < lvl) begin rw(1'b1, 1'b0, 1'b0, q); cur++; end
        while (cur > lvl) begin rw(1'b0, 1'b0, 1'b1, q); cur--; end
    endtask

    function automatic int exp_steps(input int lvl, input int sub, input int dep);
        int e = lvl * 8 + sub;
        if (e > (dep - 1) * 8) return (e - (dep - 1) * 8 > 8) ? 8 : e - (dep - 1) * 8;
        if (e < 8) return 8 - e;
        return 0;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        settle(1);
        // R10 reset state
        check("R10 fill", int'(fill), 0);
        check("R10 step_req", int'(step_req), 0);
        check("R10 sticky", int'(clk_err_sticky), 0);
        check("R10 store_err", int'(store_err), 0);

        // R1 half depth for every size code
        for (int c = 0; c < 8; c++) begin
            do_recenter(c);
            check("R1 half depth", int'(fill), dep_of(c) / 2);
        end

        // R2 strobes ignored while recenter is held
        @(negedge clk);
        size_sel = 3'd1; recenter = 1'b1;
        settle(2);
        wr_stb = 1'b1; rd_stb = 1'b0;
        settle(3);
        wr_stb = 1'b0;
        check("R2 held fill", int'(fill), 8);
        recenter = 1'b0;
        settle(2);
        cur = 8;

        // R3 ordering with offset rates: drain, write ahead, overlap, drain
        move_to(0);
        for (int i = 0; i < 12; i++) rw(1'b1, pat[i], 1'b0, got);
        for (int i = 12; i < 16; i++) begin
            rw(1'b1, pat[i], 1'b1, got);
            check("R3 overlap order", int'(got), int'(pat[i-12]));
        end
        for (int i = 4; i < 16; i++) begin
            rw(1'b0, 1'b0, 1'b1, got);
            check("R3 read order", int'(got), int'(pat[i]));
        end

        // R4 overflow on the 8-bit store
        do_recenter(0);
        move_to(8);
        check("R4 no error before slip", int'(store_err), 0);
        rw(1'b1, 1'b1, 1'b0, got);
        settle(2);
        check("R4 store_err", int'(store_err), 1);
        check("R4 fill pinned", int'(fill), 8);
        settle(5);
        check("R4 sticky", int'(store_err), 1);

        // R2 recenter clears the slip flag
        do_recenter(0);
        check("R2 store_err cleared", int'(store_err), 0);

        // R5 underrun
        move_to(0);
        check("R5 no error before slip", int'(store_err), 0);
        rw(1'b0, 1'b0, 1'b1, got);
        settle(2);
        check("R5 store_err", int'(store_err), 1);
        check("R5 fill pinned", int'(fill), 0);

        // R8 acceleration disabled at the full limit
        do_recenter(0);
        move_to(8);
        sub_phase = 3'd7;
        irq_seen = 0;
        settle(3);
        check("R8 disabled req", int'(step_req), 0);
        check("R8 disabled cnt", int'(step_cnt), 0);
        check("R8 disabled irq", irq_seen, 0);

        // R9 interrupt pulse and sticky bit
        sub_phase = 3'd0;
        do_recenter(0);
        accel_en = 1'b1;
        move_to(7);
        settle(2);
        irq_seen = 0;
        check("R9 sticky clear before", int'(clk_err_sticky), 0);
        sub_phase = 3'd3;
        settle(4);
        check("R9 irq pulses", irq_seen, 1);
        check("R9 sticky set", int'(clk_err_sticky), 1);
        sub_phase = 3'd0;
        settle(3);
        check("R9 left window", int'(step_req), 0);
        check("R9 sticky held", int'(clk_err_sticky), 1);
        do_recenter(0);
        check("R9 sticky cleared", int'(clk_err_sticky), 0);

        // R6 R7 R8 sweep of every level and sub-bit phase on two sizes
        for (int c = 0; c < 2; c++) begin
            for (int lvl = 0; lvl <= dep_of(c); lvl++) begin
                sub_phase = 3'd0;
                do_recenter(c);
                move_to(lvl);
                for (int s = 0; s < 8; s++) begin
                    int e;
                    sub_phase = 3'(s);
                    settle(3);
                    e = exp_steps(lvl, s, dep_of(c));
                    if (e == 0) begin
                        check("R8 idle req", int'(step_req), 0);
                        check("R8 idle cnt", int'(step_cnt), 0);
                    end else if (lvl * 8 + s < 8) begin
                        check("R7 slow req", int'(step_req), 1);
                        check("R7 slow dir", int'(step_up), 0);
                        check("R7 slow cnt", int'(step_cnt), e);
                    end else begin
                        check("R6 fast req", int'(step_req), 1);
                        check("R6 fast dir", int'(step_up), 1);
                        check("R6 fast cnt", int'(step_cnt), e);
                    end
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule